// File: doc/BRIEF.md
# Numerically Controlled Clock and Sine Synthesizer

This block is a numerically controlled oscillator for digital clock synthesis. On every system clock, a phase accumulator adds an effective tuning word to its own value. The top bits of the accumulator address a full-period sine table, which is inferred as block RAM. The table drives a registered two's-complement sample bus meant for a low-cost external DAC. The accumulator's most significant bit is also brought out directly as a square clock. The output frequency is the tuning word times the system clock rate, divided by two to the power of the accumulator width.

A host programs three parameters through a simple write port: the target tuning word, the largest change allowed per clock, and a dither amplitude. A change of target does not jump straight to the new word. The active word glides toward the target in bounded steps, so the frequency changes without overshoot. When the dither amplitude is non-zero, a scaled signed value taken from a free-running LFSR is added to the active word before accumulation. This spreads the spectrum of the output. The full accumulator value is also output, so that downstream logic can use the phase.

Top module: `nco_clock_synth`

## Requirements
- R1: While `rst` is high, `phaseOut`, `clkOut` and `sampleOut` are all zero.
- R2: With dither off and the glide settled, `phaseOut` increases by exactly the target tuning word every clock, modulo 2^30, wrapping silently.
- R3: With a non-zero step S, after a target write the per-clock phase increment moves toward the new target by exactly S each clock. The last move may be smaller. It never passes the target, so ceil(|new-old|/S)-1 intermediate increments are seen.
- R4: With a step of 0, the increment jumps to the new target in a single clock, with no intermediate values.
- R5: One clock after a phase value is held, `sampleOut` equals round(127*sin(2*pi*k/1024)) in 8-bit two's complement, where k = phase[29:20].
- R6: `clkOut` always equals bit 29 of `phaseOut`. For a word of 2^26 it is high for 16 of every 32 clocks.
- R7: A dither amplitude a in 1..7 adds the sign-extended low 8 LFSR bits times 2^a to the word. Each increment then lies in [W-128*2^a, W+127*2^a] and keeps varying. An amplitude of 0 disables dither.
- R8: Register addresses on `wrAddr` are: 0 = target word (30 bits), 1 = glide step (30 bits), 2 = dither amplitude (bits 2:0). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 2 | Host register address |
| wrData | input | 30 | Host write data |
| phaseOut | output | 30 | Accumulator value |
| sampleOut | output | 8 | Registered sine sample, two's complement |
| clkOut | output | 1 | Square clock from the accumulator MSB |

## Verification
The bench builds the block with its default parameters: a 30-bit accumulator, a 1024-entry table of 8-bit samples, a 16-bit LFSR and a 3-bit dither amplitude. With random words up to 2^29, the accumulator wraps within a few clocks, so modulo arithmetic is exercised constantly. Every sine sample is compared with a computed table value. A word of 2^26 gives a short, exact square-clock period. Random targets and steps produce glides of up to about thirty clocks in both directions. With the largest amplitude, the dither reaches deviations of about sixteen thousand, so its bound can be checked over many LFSR states.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } ncoStrobe_t;

  typedef enum logic [1:0] {
    REG_TARGET = 2'd0,
    REG_STEP   = 2'd1,
    REG_DITHER = 2'd2
  } regAddr_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int ACC_W     = 30,
  parameter int AMP_W     = 3,
  parameter int LFSR_W    = 16,
  parameter int DITH_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [ACC_W-1:0] wrData,
  output ncoStrobe_t       strobe,
  output logic [ACC_W-1:0] effWord,
  output logic [ACC_W-1:0] activeWord,
  output logic [ACC_W-1:0] targetWord,
  output logic [ACC_W-1:0] stepWord,
  output logic [AMP_W-1:0] ditherAmp,
  output logic [LFSR_W-1:0] lfsrState
);
  localparam int EXT_W = ACC_W - DITH_W;

  logic [ACC_W-1:0] nextActive;
  logic [ACC_W-1:0] gap;
  logic [ACC_W-1:0] ditherExt;
  logic [ACC_W-1:0] ditherScaled;
  logic [LFSR_W-1:0] lfsrNext;

  // glide: move active toward target by at most stepWord
  always_comb begin
    nextActive = activeWord;
    gap        = '0;
    if (targetWord > activeWord) begin
      gap = targetWord - activeWord;
      nextActive = (stepWord == '0 || gap <= stepWord) ? targetWord : activeWord + stepWord;
    end else if (targetWord < activeWord) begin
      gap = activeWord - targetWord;
      nextActive = (stepWord == '0 || gap <= stepWord) ? targetWord : activeWord - stepWord;
    end
  end

  // Galois LFSR step
  always_comb begin
    lfsrNext = lfsrState >> 1;
    if (lfsrState[0]) lfsrNext = lfsrNext ^ LFSR_TAPS;
  end

  // signed dither scaled by 2^amp
  always_comb begin
    ditherExt    = {{EXT_W{lfsrState[DITH_W-1]}}, lfsrState[DITH_W-1:0]};
    ditherScaled = ditherExt << ditherAmp;
    effWord      = (ditherAmp == '0) ? activeWord : activeWord + ditherScaled;
  end

  always_comb begin
    strobe.clear   = rst;
    strobe.advance = !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      targetWord <= '0;
      stepWord   <= '0;
      ditherAmp  <= '0;
      activeWord <= '0;
      lfsrState  <= LFSR_W'(1);
    end else begin
      lfsrState  <= lfsrNext;
      activeWord <= nextActive;
      if (wrEn) begin
        case (wrAddr)
          REG_TARGET: targetWord <= wrData;
          REG_STEP:   stepWord   <= wrData;
          REG_DITHER: ditherAmp  <= wrData[AMP_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W      = 30,
  parameter int TABLE_BITS = 10,
  parameter int SAMPLE_W   = 8
) (
  input  logic                clk,
  input  ncoStrobe_t          strobe,
  input  logic [ACC_W-1:0]    tuneWord,
  output logic [ACC_W-1:0]    phaseOut,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                clkOut
);
  localparam int  DEPTH = 1 << TABLE_BITS;
  localparam real AMPL  = real'((1 << (SAMPLE_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic [SAMPLE_W-1:0] sineRom [DEPTH];
  logic [ACC_W-1:0]    phaseReg;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real v;
      v = AMPL * $sin(TWO_PI * real'(i) / real'(DEPTH));
      sineRom[i] = (v >= 0.0) ? SAMPLE_W'($rtoi(v + 0.5)) : SAMPLE_W'($rtoi(v - 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        phaseReg <= '0;
    else if (strobe.advance) phaseReg <= phaseReg + tuneWord;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) sampleOut <= '0;
    else              sampleOut <= sineRom[phaseReg[ACC_W-1 -: TABLE_BITS]];
  end

  assign phaseOut = phaseReg;
  assign clkOut   = phaseReg[ACC_W-1];
endmodule

// File: rtl/nco_clock_synth.sv
module nco_clock_synth
  import nco_pkg::*;
#(
  parameter int ACC_W      = 30,
  parameter int TABLE_BITS = 10,
  parameter int SAMPLE_W   = 8,
  parameter int AMP_W      = 3,
  parameter int LFSR_W     = 16,
  parameter int DITH_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [ACC_W-1:0]    wrData,
  output logic [ACC_W-1:0]    phaseOut,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                clkOut
);
  ncoStrobe_t        strobe;
  logic [ACC_W-1:0]  effWord;
  logic [ACC_W-1:0]  activeWord;
  logic [ACC_W-1:0]  targetWord;
  logic [ACC_W-1:0]  stepWord;
  logic [AMP_W-1:0]  ditherAmp;
  logic [LFSR_W-1:0] lfsrState;

  nco_ctrl #(
    .ACC_W(ACC_W), .AMP_W(AMP_W), .LFSR_W(LFSR_W), .DITH_W(DITH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .effWord(effWord), .activeWord(activeWord),
    .targetWord(targetWord), .stepWord(stepWord), .ditherAmp(ditherAmp),
    .lfsrState(lfsrState)
  );

  nco_datapath #(
    .ACC_W(ACC_W), .TABLE_BITS(TABLE_BITS), .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk(clk), .strobe(strobe), .tuneWord(effWord),
    .phaseOut(phaseOut), .sampleOut(sampleOut), .clkOut(clkOut)
  );
endmodule

// File: rtl/nco_clock_synth_checker.sv
module nco_clock_synth_checker #(
  parameter int ACC_W  = 30,
  parameter int AMP_W  = 3,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  phaseOut,
  input logic [ACC_W-1:0]  effWord,
  input logic [ACC_W-1:0]  activeWord,
  input logic [ACC_W-1:0]  targetWord,
  input logic [ACC_W-1:0]  stepWord,
  input logic [AMP_W-1:0]  ditherAmp,
  input logic [LFSR_W-1:0] lfsrState
);
  logic [ACC_W-1:0] prevActive;
  logic             havePrev;
  logic [ACC_W-1:0] moveSize;

  always_ff @(posedge clk) begin
    prevActive <= activeWord;
    havePrev   <= !rst;
  end

  always_comb moveSize = (activeWord >= prevActive) ? activeWord - prevActive : prevActive - activeWord;

  // R2: accumulator adds the word the control presented last cycle
  a_r2_phase_advance: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phaseOut == ACC_W'($past(phaseOut) + $past(effWord)));

  // R3: one clock of glide never moves more than the programmed step
  a_r3_glide_bound: assert property (@(posedge clk) disable iff (rst)
    (havePrev && !$past(rst) && $past(stepWord) != '0) |-> moveSize <= $past(stepWord));

  // R3: glide never passes the target from below
  a_r3_no_overshoot_up: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(activeWord) <= $past(targetWord)) |-> activeWord <= $past(targetWord));

  // R3: glide never passes the target from above
  a_r3_no_overshoot_down: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(activeWord) >= $past(targetWord)) |-> activeWord >= $past(targetWord));

  // R7: dither source never locks up
  a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
    lfsrState != '0);

  // R7: amplitude zero leaves the word untouched
  a_r7_dither_off: assert property (@(posedge clk) disable iff (rst)
    ditherAmp == '0 |-> effWord == activeWord);
endmodule

bind nco_clock_synth nco_clock_synth_checker #(
  .ACC_W(ACC_W), .AMP_W(AMP_W), .LFSR_W(LFSR_W)
) u_chk (.*);

// File: tb/nco_clock_synth_bench.sv
`timescale 1ns/1ps
module nco_clock_synth_bench;
  localparam int ACC_W = 30;
  localparam logic [ACC_W-1:0] MASK = {ACC_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [ACC_W-1:0] wrData = '0;
  logic [ACC_W-1:0] phaseOut;
  logic [7:0] sampleOut;
  logic clkOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [ACC_W-1:0] prevPhase = '0;
  logic [ACC_W-1:0] curPhase = '0;
  logic [ACC_W-1:0] delta = '0;
  logic [ACC_W-1:0] caps [64];

  always #4 clk = ~clk;

  nco_clock_synth u_nco_clock_synth (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .phaseOut(phaseOut), .sampleOut(sampleOut), .clkOut(clkOut)
  );

  function automatic logic [7:0] sineRef(int k);
    real v;
    v = 127.0 * $sin(6.283185307179586 * real'(k) / 1024.0);
    return (v >= 0.0) ? 8'($rtoi(v + 0.5)) : 8'($rtoi(v - 0.5));
  endfunction

  function automatic int ceilDiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk);
    curPhase = phaseOut;
  endtask

  // advance one clock, record increment, check sample and clock pins
  task automatic capture();
    @(negedge clk);
    prevPhase = curPhase;
    curPhase  = phaseOut;
    delta     = (curPhase - prevPhase) & MASK;
    check(sampleOut == sineRef(int'(prevPhase[ACC_W-1 -: 10])), "R5 sine sample",
          sampleOut, sineRef(int'(prevPhase[ACC_W-1 -: 10])));
    check(clkOut == curPhase[ACC_W-1], "R6 clkOut equals MSB", clkOut, curPhase[ACC_W-1]);
  endtask

  task automatic hostWrite(logic [1:0] a, logic [ACC_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    curPhase = phaseOut;
  endtask

  task automatic settle(logic [ACC_W-1:0] w);
    hostWrite(2'd1, '0);
    hostWrite(2'd0, w);
    repeat (3) capture();
  endtask

  // glide from w1 to w2 with step s, check the increment sequence
  task automatic glide(logic [ACC_W-1:0] w1, logic [ACC_W-1:0] w2, int s);
    int n, mids, expMids, lo, hi;
    bit stepOk;
    settle(w1);
    hostWrite(2'd1, ACC_W'(s));
    hostWrite(2'd0, w2);
    expMids = (s == 0) ? 0 : ceilDiv((w2 > w1) ? int'(w2 - w1) : int'(w1 - w2), s) - 1;
    n = expMids + 6;
    for (int i = 0; i < n; i++) begin
      capture();
      caps[i] = delta;
    end
    lo = int'((w1 < w2) ? w1 : w2);
    hi = int'((w1 < w2) ? w2 : w1);
    mids = 0;
    stepOk = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (int'(caps[i]) > lo && int'(caps[i]) < hi) mids++;
      if (int'(caps[i]) < lo || int'(caps[i]) > hi) stepOk = 1'b0;
      if (i > 0 && s != 0 && caps[i] != caps[i-1] && caps[i] != w2) begin
        if (((caps[i] > caps[i-1]) ? caps[i] - caps[i-1] : caps[i-1] - caps[i]) != ACC_W'(s))
          stepOk = 1'b0;
      end
    end
    if (s == 0) check(mids == 0, "R4 jump without intermediates", mids, 0);
    else        check(mids == expMids, "R3 intermediate glide count", mids, expMids);
    check(stepOk, "R3 glide steps and no overshoot", stepOk, 1);
    check(caps[n-1] == w2, "R2 settled increment", caps[n-1], w2);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(phaseOut == '0, "R1 phase in reset", phaseOut, 0);
    check(clkOut == 1'b0, "R1 clkOut in reset", clkOut, 0);
    check(sampleOut == 8'd0, "R1 sample in reset", sampleOut, 0);
    rst = 1'b0;
    sync();

    // R2: steady accumulation with wrap
    settle(30'h1234567);
    for (int i = 0; i < 40; i++) begin
      capture();
      check(delta == 30'h1234567, "R2 increment", delta, 30'h1234567);
    end

    // R6: square clock duty with word 2^26
    begin
      int ones;
      settle(30'h4000000);
      ones = 0;
      for (int i = 0; i < 32; i++) begin
        capture();
        if (clkOut) ones++;
      end
      check(ones == 16, "R6 clkOut duty", ones, 16);
    end

    // R3 directed up and down, R4 jump
    glide(30'h0100000, 30'h0100000 + 30'd1000, 300);
    glide(30'h0100000 + 30'd1000, 30'h0100000, 300);
    glide(30'h0200000, 30'h0300000, 0);

    // R3 random glides
    for (int r = 0; r < 12; r++) begin
      logic [ACC_W-1:0] a, b;
      int s;
      a = ACC_W'($urandom_range(32'h1FFFFFFF, 32'h100));
      b = (($urandom & 1) != 0) ? a + ACC_W'($urandom_range(5000, 1)) : a - ACC_W'($urandom_range(5000, 1));
      s = int'($urandom_range(1000, 200));
      glide(a, b, s);
    end

    // R8: write to address 3 ignored
    settle(30'h0ABCDEF);
    hostWrite(2'd3, 30'h3FFFFFFF);
    for (int i = 0; i < 8; i++) begin
      capture();
      check(delta == 30'h0ABCDEF, "R8 unmapped write ignored", delta, 30'h0ABCDEF);
    end

    // R7: dither bounds and variation, amplitude 3 and 7
    for (int amp = 3; amp <= 7; amp += 4) begin
      logic [ACC_W-1:0] w;
      int dev, minDev, maxDev;
      w = 30'h1000000;
      settle(w);
      hostWrite(2'd2, ACC_W'(amp));
      minDev = 1 << 30; maxDev = -(1 << 30);
      for (int i = 0; i < 200; i++) begin
        capture();
        dev = int'(delta) - int'(w);
        if (dev < minDev) minDev = dev;
        if (dev > maxDev) maxDev = dev;
      end
      check(minDev >= -(128 << amp), "R7 dither lower bound", minDev, -(128 << amp));
      check(maxDev <= (127 << amp), "R7 dither upper bound", maxDev, 127 << amp);
      check(maxDev > minDev, "R7 dither varies", maxDev - minDev, 1);
      hostWrite(2'd2, '0);
      capture();
      for (int i = 0; i < 8; i++) begin
        capture();
        check(delta == w, "R7 amplitude zero disables", delta, w);
      end
    end

    // R1: reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(phaseOut == '0 && clkOut == 1'b0 && sampleOut == 8'd0, "R1 reassert reset", phaseOut, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule